// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits between a request source and a single-transaction SPI engine. The engine can only send a short burst of bytes and optionally receive a few back. A caller wants whole operations done on a serial NOR device. The sequencer accepts four kinds of request: program a byte range, erase a sector, erase a block, or erase the whole chip. It expands each one into the series of engine transactions the flash needs. Those are write enable, repeated status reads until the device reports it is idle, and the command itself.

Program data comes in on a byte stream with a valid/ready handshake. The sequencer splits a program request into small writes. Each write carries at most four bytes and never runs past the end of a 256-byte page. The sequencer fetches the bytes for each write just before it issues that write. A one-clock done pulse closes every request. A new request is accepted only when the sequencer is idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `reqReady` is 1 and `engStart`, `donePulse` and `dataReady` are all 0.
- R2: Before each program write and each erase command, the sequencer runs a write-enable transaction: opcode 0x06 in `engOpAddr[7:0]`, transmit count 1, receive count 0.
- R3: After each write enable, and after each erase command, the sequencer runs status reads (opcode 0x05, transmit 1, receive 1). It repeats them for as long as bit 0 of `engRxData` is 1, judged once `engBusy` has dropped. It ignores every other status bit.
- R4: A program write uses opcode 0x02, with the write address in `engOpAddr[31:8]` and receive count 0. Its transmit count is 4+n, where n is 1 to 4 data bytes. Data byte k of the write sits in `engData[8k+7:8k]`, and any unused lanes are 0.
- R5: Every program write is n = min(4, bytes left before the next 256-byte page boundary, bytes left in the request) long, so no write crosses a page boundary.
- R6: A request with `reqKind` 1 (sector) sends opcode 0x20, and `reqKind` 2 (block) sends opcode 0xD8. Both carry the request address in `engOpAddr[31:8]` and use transmit count 4 and receive count 0.
- R7: A request with `reqKind` 3 (chip) sends opcode 0xC7 with transmit count 1 and receive count 0.
- R8: An erase request ends with `donePulse` only after a status read has returned bit 0 clear following the erase command. A program request ends as soon as the engine finishes its last write.
- R9: `engStart` lasts one clock. It is never asserted while `engBusy` is 1. The engine raises `engBusy` in the clock after `engStart`.
- R10: Between acceptance and completion, `reqReady` is 0 and any offered request has no effect. `donePulse` lasts exactly one clock per request.
- R11: A program request (`reqKind` 0) with `reqLen` 0 completes with `donePulse` and issues no transaction.
- R12: `dataReady` is 1 only while the bytes of a program write are being gathered. A byte is consumed only when `dataValid` and `dataReady` are both 1. Offered bytes are never consumed during an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request accepted this clock |
| reqKind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| reqAddr | input | ADDR_W | Start address of the program or erase |
| reqLen | input | LEN_W | Program length in bytes |
| dataValid | input | 1 | Program byte offered |
| dataReady | output | 1 | Sequencer takes a program byte |
| dataByte | input | 8 | Program byte |
| engStart | output | 1 | Start one engine transaction |
| engTxCount | output | 4 | Bytes the engine transmits |
| engRxCount | output | 4 | Bytes the engine receives |
| engOpAddr | output | ADDR_W+8 | Opcode in bits 7:0, address above it |
| engData | output | 8*CHUNK_MAX | Write data, first byte sent in bits 7:0 |
| engBusy | input | 1 | Engine transaction in progress |
| engRxData | input | 32 | Engine receive data, status in bits 7:0 |
| donePulse | output | 1 | Request finished |

## Verification
The hardest case to reach from the ports is a program range that starts a few bytes before a page boundary and is fed with stalls on the byte stream. Only then do the three limits on the write size take turns being the smallest. The bench starts a 10-byte request at offset 0xFE and a 6-byte one at 0xFC. It withholds `dataValid` on some cycles, and the engine model reports the device as busy for a set number of status reads after each write enable and erase. The transaction log is then compared against a sequence built from the chunking rule.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int COUNT_W = 4;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SECT  = 8'h20;
  localparam logic [7:0] OP_BLOCK = 8'hD8;
  localparam logic [7:0] OP_CHIP  = 8'hC7;

  localparam int WIP_BIT = 0;

  typedef enum logic [1:0] {
    KIND_PROG  = 2'd0,
    KIND_SECT  = 2'd1,
    KIND_BLOCK = 2'd2,
    KIND_CHIP  = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    CMD_WREN = 2'd0,
    CMD_RDSR = 2'd1,
    CMD_MAIN = 2'd2
  } cmdSel_e;

  typedef struct packed {
    logic    loadReq;
    logic    takeByte;
    logic    advance;
    cmdSel_e cmdSel;
  } seqStrobe_t;

endpackage

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int CHUNK_MAX  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strb,
  input  logic [1:0]                reqKind,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LEN_W-1:0]          reqLen,
  input  logic [7:0]                dataByte,
  input  logic [31:0]               engRxData,
  output logic                      reqEmpty,
  output logic                      kindIsProg,
  output logic                      lastChunk,
  output logic                      lastByte,
  output logic                      statusWip,
  output logic [COUNT_W-1:0]        engTxCount,
  output logic [COUNT_W-1:0]        engRxCount,
  output logic [ADDR_W+7:0]         engOpAddr,
  output logic [8*CHUNK_MAX-1:0]    engData
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(CHUNK_MAX + 1);
  localparam int SZW    = (LEN_W > PAGE_W) ? LEN_W + 1 : PAGE_W + 2;

  reqKind_e           kindQ;
  logic [ADDR_W-1:0]  curAddr;
  logic [LEN_W-1:0]   remaining;
  logic [CNT_W-1:0]   fillCnt;
  logic [CNT_W-1:0]   chunkLen;
  logic               unusedRxBits;

  assign reqEmpty     = (reqKind_e'(reqKind) == KIND_PROG) && (reqLen == '0);
  assign kindIsProg   = (kindQ == KIND_PROG);
  assign statusWip    = engRxData[WIP_BIT];
  assign unusedRxBits = ^engRxData[31:1];

  // request registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ     <= KIND_PROG;
      curAddr   <= '0;
      remaining <= '0;
    end else if (strb.loadReq) begin
      kindQ     <= reqKind_e'(reqKind);
      curAddr   <= reqAddr;
      remaining <= reqLen;
    end else if (strb.advance) begin
      curAddr   <= curAddr + ADDR_W'(chunkLen);
      remaining <= remaining - LEN_W'(chunkLen);
    end
  end

  // write size: smallest of the lane count, the page remainder and the request remainder
  logic [SZW-1:0] pageLeft, remLeft, pick;
  always_comb begin
    pageLeft = SZW'(PAGE_BYTES) - SZW'(curAddr[PAGE_W-1:0]);
    remLeft  = SZW'(remaining);
    pick     = SZW'(CHUNK_MAX);
    if (pageLeft < pick) pick = pageLeft;
    if (remLeft < pick) pick = remLeft;
    chunkLen = CNT_W'(pick);
  end

  assign lastChunk = (remaining == LEN_W'(chunkLen));
  assign lastByte  = (CNT_W'(fillCnt + 1'b1) == chunkLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (strb.loadReq || strb.advance) begin
      fillCnt <= '0;
    end else if (strb.takeByte) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  // one byte lane per data slot, filled from the lowest lane upward
  for (genvar g = 0; g < CHUNK_MAX; g++) begin : gLane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (strb.loadReq || strb.advance) begin
        laneQ <= '0;
      end else if (strb.takeByte && (fillCnt == CNT_W'(g))) begin
        laneQ <= dataByte;
      end
    end
    assign engData[8*g +: 8] = laneQ;
  end

  // transaction field selection
  always_comb begin
    engOpAddr  = {curAddr, OP_WREN};
    engTxCount = COUNT_W'(1);
    engRxCount = '0;
    unique case (strb.cmdSel)
      CMD_WREN: begin
        engOpAddr = {curAddr, OP_WREN};
      end
      CMD_RDSR: begin
        engOpAddr  = {curAddr, OP_RDSR};
        engRxCount = COUNT_W'(1);
      end
      default: begin
        unique case (kindQ)
          KIND_PROG: begin
            engOpAddr  = {curAddr, OP_PROG};
            engTxCount = COUNT_W'(4) + COUNT_W'(chunkLen);
          end
          KIND_SECT: begin
            engOpAddr  = {curAddr, OP_SECT};
            engTxCount = COUNT_W'(4);
          end
          KIND_BLOCK: begin
            engOpAddr  = {curAddr, OP_BLOCK};
            engTxCount = COUNT_W'(4);
          end
          default: begin
            engOpAddr  = {curAddr, OP_CHIP};
            engTxCount = COUNT_W'(1);
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqEmpty,
  input  logic       engBusy,
  input  logic       statusWip,
  input  logic       kindIsProg,
  input  logic       lastChunk,
  input  logic       lastByte,
  input  logic       dataValid,
  output seqStrobe_t strb,
  output logic       reqReady,
  output logic       dataReady,
  output logic       engStart,
  output logic       donePulse
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_WREN,
    S_WREN_WAIT,
    S_POLL,
    S_POLL_WAIT,
    S_FILL,
    S_CMD,
    S_CMD_WAIT,
    S_DONE
  } state_e;

  state_e state, nextState;
  logic   afterCmd, afterCmdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      afterCmd <= 1'b0;
    end else begin
      state    <= nextState;
      afterCmd <= afterCmdNext;
    end
  end

  always_comb begin
    nextState     = state;
    afterCmdNext  = afterCmd;
    strb.loadReq  = 1'b0;
    strb.takeByte = 1'b0;
    strb.advance  = 1'b0;
    strb.cmdSel   = CMD_MAIN;
    reqReady      = 1'b0;
    dataReady     = 1'b0;
    engStart      = 1'b0;
    donePulse     = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.loadReq = 1'b1;
          nextState    = reqEmpty ? S_DONE : S_WREN;
        end
      end
      S_WREN: begin
        strb.cmdSel  = CMD_WREN;
        engStart     = 1'b1;
        afterCmdNext = 1'b0;
        nextState    = S_WREN_WAIT;
      end
      S_WREN_WAIT: begin
        strb.cmdSel = CMD_WREN;
        if (!engBusy) nextState = S_POLL;
      end
      S_POLL: begin
        strb.cmdSel = CMD_RDSR;
        engStart    = 1'b1;
        nextState   = S_POLL_WAIT;
      end
      S_POLL_WAIT: begin
        strb.cmdSel = CMD_RDSR;
        if (!engBusy) begin
          if (statusWip)       nextState = S_POLL;
          else if (afterCmd)   nextState = S_DONE;
          else if (kindIsProg) nextState = S_FILL;
          else                 nextState = S_CMD;
        end
      end
      S_FILL: begin
        dataReady = 1'b1;
        if (dataValid) begin
          strb.takeByte = 1'b1;
          if (lastByte) nextState = S_CMD;
        end
      end
      S_CMD: begin
        engStart  = 1'b1;
        nextState = S_CMD_WAIT;
      end
      S_CMD_WAIT: begin
        if (!engBusy) begin
          if (kindIsProg) begin
            strb.advance = 1'b1;
            nextState    = lastChunk ? S_DONE : S_WREN;
          end else begin
            afterCmdNext = 1'b1;
            nextState    = S_POLL;
          end
        end
      end
      S_DONE: begin
        donePulse = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int CHUNK_MAX  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqKind,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic                   dataValid,
  output logic                   dataReady,
  input  logic [7:0]             dataByte,
  output logic                   engStart,
  output logic [3:0]             engTxCount,
  output logic [3:0]             engRxCount,
  output logic [ADDR_W+7:0]      engOpAddr,
  output logic [8*CHUNK_MAX-1:0] engData,
  input  logic                   engBusy,
  input  logic [31:0]            engRxData,
  output logic                   donePulse
);

  seqStrobe_t strb;
  logic reqEmpty, kindIsProg, lastChunk, lastByte, statusWip;

  flash_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqEmpty   (reqEmpty),
    .engBusy    (engBusy),
    .statusWip  (statusWip),
    .kindIsProg (kindIsProg),
    .lastChunk  (lastChunk),
    .lastByte   (lastByte),
    .dataValid  (dataValid),
    .strb       (strb),
    .reqReady   (reqReady),
    .dataReady  (dataReady),
    .engStart   (engStart),
    .donePulse  (donePulse)
  );

  flash_seq_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CHUNK_MAX  (CHUNK_MAX)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqKind    (reqKind),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .dataByte   (dataByte),
    .engRxData  (engRxData),
    .reqEmpty   (reqEmpty),
    .kindIsProg (kindIsProg),
    .lastChunk  (lastChunk),
    .lastByte   (lastByte),
    .statusWip  (statusWip),
    .engTxCount (engTxCount),
    .engRxCount (engRxCount),
    .engOpAddr  (engOpAddr),
    .engData    (engData)
  );

endmodule

// File: rtl/flash_cmd_seq_checker.sv
module flash_cmd_seq_checker
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              dataReady,
  input logic              engStart,
  input logic              engBusy,
  input logic [3:0]        engTxCount,
  input logic [3:0]        engRxCount,
  input logic [ADDR_W+7:0] engOpAddr,
  input logic              donePulse
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);

  AST_WREN_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engOpAddr[7:0] == OP_WREN) |-> (engTxCount == 4'd1 && engRxCount == 4'd0)); // R2

  AST_POLL_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engOpAddr[7:0] == OP_RDSR) |-> (engTxCount == 4'd1 && engRxCount == 4'd1)); // R3

  AST_PROG_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engOpAddr[7:0] == OP_PROG) |-> (engTxCount >= 4'd5 && engTxCount <= 4'd8 && engRxCount == 4'd0)); // R4

  AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engOpAddr[7:0] == OP_PROG) |->
      (32'(engOpAddr[8 +: PAGE_W]) + 32'(engTxCount) - 32'd4 <= 32'(PAGE_BYTES))); // R5

  AST_ERASE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && (engOpAddr[7:0] == OP_SECT || engOpAddr[7:0] == OP_BLOCK)) |-> (engTxCount == 4'd4)); // R6

  AST_CHIP_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engOpAddr[7:0] == OP_CHIP) |-> (engTxCount == 4'd1)); // R7

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart); // R9

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engBusy |-> !engStart); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R10

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (engStart || donePulse) |-> !reqReady); // R10

  AST_FILL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> (!engStart && !engBusy && !reqReady)); // R12

endmodule

bind flash_cmd_seq flash_cmd_seq_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .dataReady  (dataReady),
  .engStart   (engStart),
  .engBusy    (engBusy),
  .engTxCount (engTxCount),
  .engRxCount (engRxCount),
  .engOpAddr  (engOpAddr),
  .donePulse  (donePulse)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic        dataValid = 1'b0;
  logic        dataReady;
  logic [7:0]  dataByte = '0;
  logic        engStart;
  logic [3:0]  engTxCount, engRxCount;
  logic [31:0] engOpAddr;
  logic [31:0] engData;
  logic        engBusy;
  logic [31:0] engRxData;
  logic        donePulse;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int cfgPolls = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqLen(reqLen),
    .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte),
    .engStart(engStart), .engTxCount(engTxCount), .engRxCount(engRxCount),
    .engOpAddr(engOpAddr), .engData(engData), .engBusy(engBusy),
    .engRxData(engRxData), .donePulse(donePulse)
  );

  // engine model with transaction log
  logic [7:0]  logOp   [512];
  logic [3:0]  logTx   [512];
  logic [3:0]  logRx   [512];
  logic [23:0] logAddr [512];
  logic [31:0] logData [512];
  int logN, busyLeft, pollsLeft, startWhileBusy, startBackToBack;
  logic prevStart;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engBusy <= 1'b0; busyLeft <= 0; engRxData <= '0; pollsLeft <= 0;
      logN <= 0; startWhileBusy <= 0; startBackToBack <= 0; prevStart <= 1'b0;
    end else begin
      prevStart <= engStart;
      if (engStart && prevStart) startBackToBack <= startBackToBack + 1;
      if (engStart) begin
        if (engBusy) startWhileBusy <= startWhileBusy + 1;
        engBusy  <= 1'b1;
        busyLeft <= 2;
        if (logN < 512) begin
          logOp[logN]   <= engOpAddr[7:0];
          logTx[logN]   <= engTxCount;
          logRx[logN]   <= engRxCount;
          logAddr[logN] <= engOpAddr[31:8];
          logData[logN] <= engData;
        end
        logN <= logN + 1;
        case (engOpAddr[7:0])
          8'h05: begin
            engRxData <= {24'h0, (pollsLeft > 0) ? 8'h83 : 8'hFE};
            if (pollsLeft > 0) pollsLeft <= pollsLeft - 1;
          end
          8'h06, 8'h20, 8'hD8, 8'hC7: pollsLeft <= cfgPolls;
          default: ;
        endcase
      end else if (busyLeft > 0) begin
        busyLeft <= busyLeft - 1;
      end else begin
        engBusy <= 1'b0;
      end
    end
  end

  // expected transaction list
  logic [7:0]  expOp   [512];
  logic [3:0]  expTx   [512];
  logic [3:0]  expRx   [512];
  logic [23:0] expAddr [512];
  logic [31:0] expData [512];
  int expN;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] op, logic [3:0] tx, logic [3:0] rx, logic [23:0] a, logic [31:0] d);
    expOp[expN] = op; expTx[expN] = tx; expRx[expN] = rx; expAddr[expN] = a; expData[expN] = d;
    expN++;
  endtask

  task automatic pushPolls();
    for (int p = 0; p <= cfgPolls; p++) push(8'h05, 4'd1, 4'd1, '0, '0); // R3
  endtask

  task automatic buildProgram(int addr, int len);
    int a, left, off, n;
    logic [31:0] d;
    a = addr; left = len; off = 0;
    while (left > 0) begin
      n = 4;
      if (256 - (a % 256) < n) n = 256 - (a % 256);
      if (left < n) n = left; // R5
      push(8'h06, 4'd1, 4'd0, '0, '0);
      pushPolls();
      d = '0;
      for (int k = 0; k < n; k++) d[8*k +: 8] = pat(off + k);
      push(8'h02, 4'(4 + n), 4'd0, 24'(a), d);
      a += n; left -= n; off += n;
    end
  endtask

  function automatic string reqOf(logic [7:0] op);
    case (op)
      8'h06: return "R2";
      8'h05: return "R3";
      8'h02: return "R4/R5";
      8'h20, 8'hD8: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compareLog(int base, string req);
    check(logN - base == expN, req, "transaction count", logN - base, expN);
    for (int i = 0; i < expN && base + i < logN; i++) begin
      check(logOp[base+i] == expOp[i], reqOf(expOp[i]), $sformatf("opcode #%0d", i), logOp[base+i], expOp[i]);
      check(logTx[base+i] == expTx[i] && logRx[base+i] == expRx[i], reqOf(expOp[i]),
            $sformatf("counts #%0d", i), {logTx[base+i], logRx[base+i]}, {expTx[i], expRx[i]});
      if (expOp[i] != 8'h06 && expOp[i] != 8'h05 && expOp[i] != 8'hC7)
        check(logAddr[base+i] == expAddr[i], reqOf(expOp[i]), $sformatf("address #%0d", i), logAddr[base+i], expAddr[i]);
      if (expOp[i] == 8'h02)
        check(logData[base+i] == expData[i], "R4", $sformatf("data #%0d", i), logData[base+i], expData[i]);
    end
  endtask

  // run one request to completion; data fed from pat()
  task automatic runReq(logic [1:0] kind, int addr, int len, bit gaps, bit intrude, bit pushBytes, output int base, output int taken);
    int doneCnt, cyc;
    bit seenDone, finished, fed;
    @(negedge clk);
    base = logN;
    check(reqReady == 1'b1, "R10", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqKind = kind; reqAddr = 24'(addr); reqLen = 16'(len);
    @(negedge clk);
    reqValid = 1'b0;
    taken = 0; doneCnt = 0; seenDone = 0; finished = 0; cyc = 0;
    while (!finished && cyc < 3000) begin
      if (donePulse) begin doneCnt++; seenDone = 1; end
      else if (seenDone) finished = 1;
      if (intrude && cyc < 8) begin
        reqValid = 1'b1; reqKind = 2'd3;
        check(reqReady == 1'b0, "R10", "ready while active", reqReady, 0);
      end else begin
        reqValid = 1'b0;
      end
      if (pushBytes) begin
        dataValid = 1'b1; dataByte = 8'hA5;
        check(dataReady == 1'b0, "R12", "ready during erase", dataReady, 0);
      end else begin
        fed = (taken < len) && !(gaps && (cyc % 3 == 1));
        dataValid = fed;
        dataByte = fed ? pat(taken) : 8'h00;
        if (fed && dataReady) taken++;
      end
      if (!finished) begin
        @(negedge clk);
        cyc++;
      end
    end
    reqValid = 1'b0; dataValid = 1'b0;
    check(finished, "R10", "request completed", finished, 1);
    check(doneCnt == 1, "R10", "done pulse width", doneCnt, 1);
    check(reqReady == 1'b1, "R10", "ready after done", reqReady, 1);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check(engStart == 1'b0 && donePulse == 1'b0 && dataReady == 1'b0, "R1", "outputs quiet",
          {engStart, donePulse, dataReady}, 0);
  endtask

  task automatic testProgram(int addr, int len, int polls, bit gaps, string req);
    int base, taken;
    cfgPolls = polls; expN = 0;
    buildProgram(addr, len);
    runReq(2'd0, addr, len, gaps, 1'b0, 1'b0, base, taken);
    check(taken == len, "R12", "bytes consumed", taken, len);
    compareLog(base, req);
  endtask

  task automatic testEmpty();
    int base, taken;
    cfgPolls = 0; expN = 0;
    runReq(2'd0, 24'h000040, 0, 1'b0, 1'b0, 1'b0, base, taken);
    check(logN == base, "R11", "no transaction for empty program", logN - base, 0);
  endtask

  task automatic testErase(logic [1:0] kind, int addr, int polls, bit intrude);
    int base, taken;
    logic [7:0] op;
    cfgPolls = polls; expN = 0;
    op = (kind == 2'd1) ? 8'h20 : (kind == 2'd2) ? 8'hD8 : 8'hC7;
    push(8'h06, 4'd1, 4'd0, '0, '0);
    pushPolls();
    push(op, (kind == 2'd3) ? 4'd1 : 4'd4, 4'd0, 24'(addr), '0);
    pushPolls(); // R8: polling after the erase precedes done
    runReq(kind, addr, 0, 1'b0, intrude, 1'b1, base, taken);
    compareLog(base, "R8");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();                                   // R1
    rstN = 1'b1;
    @(negedge clk);
    testReset();                                   // R1
    testProgram(24'h000010, 3, 0, 1'b0, "R4");     // single short write
    testProgram(24'h0000FE, 10, 1, 1'b1, "R5");    // crosses a page, stalled stream
    testProgram(24'h1234FC, 6, 3, 1'b0, "R5");     // page remainder exactly four
    testEmpty();                                   // R11
    testErase(2'd1, 24'h345000, 2, 1'b1);          // R6, R10 refused request, R12
    testErase(2'd2, 24'h7F0000, 1, 1'b0);          // R6
    testErase(2'd3, 24'h000000, 2, 1'b0);          // R7
    check(startWhileBusy == 0, "R9", "start while busy", startWhileBusy, 0);
    check(startBackToBack == 0, "R9", "start longer than a clock", startBackToBack, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule